// File: doc/BRIEF.md
# Ripple-Carry Slice ALU with Signed Compare

This block is a combinational arithmetic-logic unit for a 32-bit integer datapath. It is built from one-bit slices connected by a ripple carry chain. Each slice holds a full adder, an AND gate, an OR gate and a four-way output selector. The same two-bit select drives every slice. A single invert control complements the B operand before it reaches any slice. An external carry-in enters the lowest slice.

Setting the invert control and driving a carry-in of 1 turns the adder into a subtractor. The top slice is built differently from the others. It brings out the sign of its adder sum, which is fed back to the "less" input of slice 0. This makes the compare operation produce a 0 or 1 result. The top slice also flags signed overflow, using the carry into it and the carry out of it. A zero detector spans the whole result word.

The block has no clock and no storage. It has no states and no transitions, so every output follows the inputs directly. A decoder upstream usually maps its four-bit control codes onto the inputs as follows:
- 0000: AND
- 0001: OR
- 0010: add (invert=0, carry-in 0)
- 0110: subtract (invert=1, carry-in 1)
- 0111: set-less-than (invert=1, carry-in 1)

Top module: `alu_slice_chain`

## Requirements
- R1: With op_sel = 2'b00 the result is the bitwise AND of A and the effective B. The effective B is B when invert_b is 0 and ~B when invert_b is 1.
- R2: With op_sel = 2'b01 the result is the bitwise OR of A and the effective B.
- R3: With op_sel = 2'b10 the result is A + effective B + carry_in, taken modulo 2^32.
- R4: invert_b = 1 with carry_in = 1 and op_sel = 2'b10 gives A − B modulo 2^32.
- R5: With op_sel = 2'b11, result bits 31..1 are 0. Bit 0 equals bit 31 of the sum A + effective B + carry_in, so with invert_b = 1 and carry_in = 1 it is the raw sign of A − B.
- R6: zero is 1 exactly when all 32 result bits are 0, whatever the operation.
- R7: overflow is 1 exactly when A[31] equals effective-B[31] and bit 31 of the sum differs from A[31]. It is the XOR of the carry into and out of the top slice, and it does not depend on op_sel.
- R8: invert_b also applies in the logic operations: with invert_b = 1, op 2'b00 gives A & ~B and op 2'b01 gives A | ~B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| invert_b | input | 1 | Complement B before the slices |
| carry_in | input | 1 | Carry into slice 0 |
| op_sel | input | 2 | 00 AND, 01 OR, 10 sum, 11 less |
| result | output | 32 | ALU result |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the sum |

## Verification
The block has no registers, so a broken carry link, a miswired select or a wrong "less" connection shows up on result in the same evaluation as the faulty input. A bad carry link shows only in operand pairs whose carry actually crosses that slice, so the vectors include full-carry patterns such as all-ones plus one. A misplaced feedback of the compare bit shows up only under op 11, where the upper bits must be zero. An error in the overflow logic shows up only at the signed boundaries.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

endpackage

// File: rtl/alu_full_add.sv
module alu_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       cout_o
);
    logic sum_w;

    alu_full_add u_fa (
        .x_i (a_i),
        .y_i (b_i),
        .c_i (cin_i),
        .s_o (sum_w),
        .c_o (cout_o)
    );

    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_i;
            SEL_OR:   res_o = a_i | b_i;
            SEL_SUM:  res_o = sum_w;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_slice_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       set_o,
    output logic       ovf_o
);
    logic sum_w;
    logic cout_w;

    alu_full_add u_fa (
        .x_i (a_i),
        .y_i (b_i),
        .c_i (cin_i),
        .s_o (sum_w),
        .c_o (cout_w)
    );

    always_comb begin
        set_o = sum_w;
        ovf_o = cin_i ^ cout_w;
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_i;
            SEL_OR:   res_o = a_i | b_i;
            SEL_SUM:  res_o = sum_w;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);
    always_comb zero_o = ~|word_i;
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             invert_b,
    input  logic             carry_in,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    slice_sel_e       sel_w;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] carry;
    logic             set_w;

    always_comb begin
        sel_w = slice_sel_e'(op_sel);
        b_eff = invert_b ? ~opnd_b : opnd_b;
    end

    assign carry[0] = carry_in;

    for (genvar gi = 0; gi < MSB; gi++) begin : g_slice
        logic less_w;
        if (gi == 0) begin : g_lsb
            assign less_w = set_w;
        end else begin : g_mid
            assign less_w = 1'b0;
        end
        alu_bit_slice u_slice (
            .a_i    (opnd_a[gi]),
            .b_i    (b_eff[gi]),
            .cin_i  (carry[gi]),
            .less_i (less_w),
            .sel_i  (sel_w),
            .res_o  (result[gi]),
            .cout_o (carry[gi+1])
        );
    end

    alu_msb_slice u_msb (
        .a_i    (opnd_a[MSB]),
        .b_i    (b_eff[MSB]),
        .cin_i  (carry[MSB]),
        .less_i (1'b0),
        .sel_i  (sel_w),
        .res_o  (result[MSB]),
        .set_o  (set_w),
        .ovf_o  (overflow)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i (result),
        .zero_o (zero)
    );

    logic [WIDTH-1:0] sum_ref;
    always_comb begin
        sum_ref = opnd_a + b_eff + WIDTH'(carry_in);
        if (sel_w == SEL_AND)
            AST_AND_BITWISE: assert (result == (opnd_a & b_eff)); // R1
        if (sel_w == SEL_OR)
            AST_OR_BITWISE: assert (result == (opnd_a | b_eff)); // R2
        if (sel_w == SEL_SUM)
            AST_SUM_MATCH: assert (result == sum_ref); // R3
        if (sel_w == SEL_LESS)
            AST_LESS_UPPER_CLEAR: assert (result[MSB:1] == '0); // R5
        if (sel_w == SEL_LESS)
            AST_LESS_BIT0: assert (result[0] == sum_ref[MSB]); // R5
        AST_OVERFLOW_SIGNS: assert (overflow ==
            ((opnd_a[MSB] == b_eff[MSB]) && (sum_ref[MSB] != opnd_a[MSB]))); // R7
    end
endmodule

// File: tb/test_alu_slice_chain.sv
module test_alu_slice_chain;
    logic        clk = 1'b0;
    logic [31:0] opnd_a, opnd_b;
    logic        invert_b, carry_in;
    logic [1:0]  op_sel;
    logic [31:0] result;
    logic        zero, overflow;
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #2.5 clk = ~clk;

    alu_slice_chain i_alu_slice_chain (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .invert_b (invert_b),
        .carry_in (carry_in),
        .op_sel   (op_sel),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic inv, logic ci, logic [1:0] op);
        @(negedge clk);
        opnd_a = a; opnd_b = b; invert_b = inv; carry_in = ci; op_sel = op;
        #1;
    endtask

    // Computes expectations from the requirement text and compares all outputs.
    task automatic run_vec(string req, logic [31:0] a, logic [31:0] b, logic inv, logic ci, logic [1:0] op);
        logic [31:0] be, s, exp;
        logic        ov;
        apply(a, b, inv, ci, op);
        be = inv ? ~b : b;
        s  = a + be + {31'd0, ci};
        ov = (a[31] == be[31]) && (s[31] != a[31]);
        case (op)
            2'b00: exp = a & be;
            2'b01: exp = a | be;
            2'b10: exp = s;
            default: exp = {31'd0, s[31]};
        endcase
        check(req, result, exp);
        check({req, "/R6"}, {31'd0, zero}, {31'd0, exp == 32'd0});
        check({req, "/R7"}, {31'd0, overflow}, {31'd0, ov});
    endtask

    task automatic t_idle;
        apply(32'd0, 32'd0, 1'b0, 1'b0, 2'b00);
        check("R6 idle zero", {31'd0, zero}, 32'd1);
        check("R1 idle result", result, 32'd0);
        check("R7 idle ovf", {31'd0, overflow}, 32'd0);
    endtask

    task automatic t_logic;
        run_vec("R1", 32'hF0F0_A5A5, 32'hFF00_0FF0, 1'b0, 1'b0, 2'b00);
        run_vec("R2", 32'hF0F0_A5A5, 32'h0F00_0FF0, 1'b0, 1'b0, 2'b01);
        run_vec("R8", 32'hF0F0_A5A5, 32'hFF00_0FF0, 1'b1, 1'b0, 2'b00);
        run_vec("R8", 32'h0000_1234, 32'hFFFF_0000, 1'b1, 1'b0, 2'b01);
        run_vec("R1", 32'h1234_5678, 32'h0000_0000, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_add;
        run_vec("R3", 32'h0000_0003, 32'h0000_0004, 1'b0, 1'b0, 2'b10);
        run_vec("R3", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b10);
        run_vec("R3", 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 2'b10);
        run_vec("R7", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b10);
        run_vec("R7", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 2'b10);
    endtask

    task automatic t_sub;
        run_vec("R4", 32'd100, 32'd58, 1'b1, 1'b1, 2'b10);
        check("R4 diff", result, 32'd42);
        run_vec("R4", 32'd5, 32'd5, 1'b1, 1'b1, 2'b10);
        run_vec("R4", 32'd3, 32'd7, 1'b1, 1'b1, 2'b10);
        run_vec("R7", 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 2'b10);
    endtask

    task automatic t_slt;
        run_vec("R5", 32'd3, 32'd7, 1'b1, 1'b1, 2'b11);
        check("R5 lt", result, 32'd1);
        run_vec("R5", 32'd7, 32'd3, 1'b1, 1'b1, 2'b11);
        run_vec("R5", 32'hFFFF_FFFE, 32'd1, 1'b1, 1'b1, 2'b11);
        run_vec("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'b11);
        run_vec("R5", 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 2'b11);
    endtask

    task automatic t_sweep;
        logic [31:0] v;
        v = 32'h1357_9BDF;
        for (int k = 0; k < 40; k++) begin
            v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]} + 32'h9E37_79B9;
            run_vec("R3", v, {v[15:0], v[31:16]}, k[0], k[1], k[3:2]);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        opnd_a = '0; opnd_b = '0; invert_b = 0; carry_in = 0; op_sel = 2'b00;
        t_idle();
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_sweep();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule